// File: doc/BRIEF.md
# H3 Universal Hash Set-Index Unit

This block maps a 32-bit IPv4 destination address to a cache set index. A key is taken from a parameterised slice of the address. Each key bit owns one programmable row of a boolean matrix, and each row is as wide as the set index. The index is the XOR of every row whose key bit is 1. This is the H3 class of universal hash, so the mixing is set entirely by the programmed matrix rather than fixed in logic.

By default the key is the 16 middle bits `dst_addr[23:8]`. The top byte and the bottom byte of the address do not affect the index. If the address bits are numbered from 1 at the MSB, the key covers positions 9 through 24. Setting the key parameters to cover all 32 bits gives a full-address hash with the same ports.

Software or a loader writes one matrix row per cycle through the row port. A lookup is presented with `key_valid`. The index is registered and appears one cycle later with `idx_valid`. A two-bank cache instantiates the unit twice, one per bank, and loads each instance with a different matrix.

Top module: `h3_index_unit`

## Requirements
- R1: After reset `idx_valid` is 0, `idx` is 0 and every matrix row is zero, so any lookup made before the first row write returns index 0.
- R2: The index equals the XOR, over every key bit k, of matrix row k where key bit k is 1. Key bit k is `dst_addr[KEY_LSB+k]`, which at the defaults (KEY_LSB=8, KEY_W=16) is the slice `dst_addr[23:8]`.
- R3: With the default parameters, `dst_addr[31:24]` and `dst_addr[7:0]` have no effect on the index.
- R4: `idx_valid` is 1 in the cycle after a cycle with `key_valid` high, and 0 in the cycle after a cycle with it low. `idx` changes only in the cycle after a lookup and holds its value otherwise.
- R5: When `row_we` is high at a rising clock edge, `row_data` replaces matrix row `row_sel`, and row k is the row paired with key bit k.
- R6: When a row write and a lookup fall in the same cycle, the lookup uses the matrix contents from before the write.
- R7: A key of all zeros yields index 0, whatever the matrix holds.
- R8: Two instances share no state. A row write to one instance leaves the other instance's results unchanged.
- R9: With KEY_LSB=0 and KEY_W=32, the unit hashes the full address through 32 rows, and `row_sel` widens to 5 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| row_we | input | 1 | Matrix row write enable |
| row_sel | input | ROW_AW | Row to write; row k pairs with key bit k |
| row_data | input | IDX_W | New contents of the selected row |
| key_valid | input | 1 | A lookup is presented this cycle |
| dst_addr | input | 32 | Destination address to hash |
| idx_valid | output | 1 | `idx` holds the result of the previous cycle's lookup |
| idx | output | IDX_W | Registered cache set index |

## Verification
The assertions check on every cycle:
- the one-cycle valid timing and the holding of `idx` between lookups;
- the zero result for an all-zero key;
- the zero result for every lookup made before any row has been written.

Whether the XOR combines the correct rows can only be shown by the bench's scenarios. The same holds for the ignored address bytes, write-before-read ordering within a cycle, independence of two instances and the 32-bit full-key variant. The bench checks these against a hand-derived matrix and a reference fold of the address bytes.

// File: rtl/h3_pkg.sv
`timescale 1ns/1ps
package h3_pkg;
  localparam int unsigned ADDR_W      = 32;
  localparam int unsigned DEF_KEY_LSB = 8;
  localparam int unsigned DEF_KEY_W   = 16;
  localparam int unsigned DEF_IDX_W   = 8;
endpackage

// File: rtl/h3_key_select.sv
`timescale 1ns/1ps
// Extracts the hash key slice from the destination address.
module h3_key_select
  import h3_pkg::*;
#(
  parameter int unsigned KEY_LSB = DEF_KEY_LSB,
  parameter int unsigned KEY_W   = DEF_KEY_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [KEY_W-1:0]  key
);
  logic unused_addr_bits;
  assign unused_addr_bits = ^addr;

  for (genvar k = 0; k < KEY_W; k++) begin : g_bit
    assign key[k] = addr[KEY_LSB + k];
  end
endmodule

// File: rtl/h3_row_store.sv
`timescale 1ns/1ps
// Programmable matrix: one IDX_W-bit row per key bit, one row written per cycle.
module h3_row_store #(
  parameter  int unsigned KEY_W  = 16,
  parameter  int unsigned IDX_W  = 8,
  localparam int unsigned ROW_AW = (KEY_W > 1) ? $clog2(KEY_W) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [ROW_AW-1:0]           sel,
  input  logic [IDX_W-1:0]            wdata,
  output logic [KEY_W-1:0][IDX_W-1:0] rows
);
  logic [KEY_W-1:0][IDX_W-1:0] rows_d;

  for (genvar k = 0; k < KEY_W; k++) begin : g_row
    logic hit;
    assign hit = we && (sel == ROW_AW'(k));

    always_comb begin
      rows_d[k] = rows[k];
      if (hit) rows_d[k] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rows[k] <= '0;
      else if (hit) rows[k] <= rows_d[k];
    end
  end
endmodule

// File: rtl/h3_xor_fold.sv
`timescale 1ns/1ps
// Combinational H3 fold: XOR of every row whose key bit is set.
module h3_xor_fold #(
  parameter int unsigned KEY_W = 16,
  parameter int unsigned IDX_W = 8
) (
  input  logic [KEY_W-1:0]            key,
  input  logic [KEY_W-1:0][IDX_W-1:0] rows,
  output logic [IDX_W-1:0]            hash
);
  logic [KEY_W-1:0][IDX_W-1:0] masked;

  for (genvar k = 0; k < KEY_W; k++) begin : g_mask
    assign masked[k] = rows[k] & {IDX_W{key[k]}};
  end

  always_comb begin
    hash = '0;
    for (int k = 0; k < KEY_W; k++) hash ^= masked[k];
  end
endmodule

// File: rtl/h3_index_unit.sv
`timescale 1ns/1ps
module h3_index_unit
  import h3_pkg::*;
#(
  parameter  int unsigned KEY_LSB = DEF_KEY_LSB,
  parameter  int unsigned KEY_W   = DEF_KEY_W,
  parameter  int unsigned IDX_W   = DEF_IDX_W,
  localparam int unsigned ROW_AW  = (KEY_W > 1) ? $clog2(KEY_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_we,
  input  logic [ROW_AW-1:0] row_sel,
  input  logic [IDX_W-1:0]  row_data,
  input  logic              key_valid,
  input  logic [ADDR_W-1:0] dst_addr,
  output logic              idx_valid,
  output logic [IDX_W-1:0]  idx
);
  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [KEY_W-1:0]            key;
  logic [KEY_W-1:0][IDX_W-1:0] rows;
  logic [IDX_W-1:0]            hash;

  h3_key_select #(.KEY_LSB(KEY_LSB), .KEY_W(KEY_W)) u_key (
    .addr (dst_addr),
    .key  (key)
  );

  h3_row_store #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_rows (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (row_we),
    .sel   (row_sel),
    .wdata (row_data),
    .rows  (rows)
  );

  h3_xor_fold #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_fold (
    .key  (key),
    .rows (rows),
    .hash (hash)
  );

  // Output register: next state, then flops.
  logic [IDX_W-1:0] idx_d;
  logic             vld_d;

  always_comb begin
    vld_d = key_valid;
    idx_d = idx;
    if (key_valid) idx_d = hash;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      idx_valid <= 1'b0;
      idx       <= '0;
    end else begin
      idx_valid <= vld_d;
      if (key_valid) idx <= idx_d;
    end
  end
endmodule

// File: rtl/h3_index_chk.sv
`timescale 1ns/1ps
module h3_index_chk
  import h3_pkg::*;
#(
  parameter int unsigned KEY_LSB = DEF_KEY_LSB,
  parameter int unsigned KEY_W   = DEF_KEY_W,
  parameter int unsigned IDX_W   = DEF_IDX_W
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              row_we,
  input logic              key_valid,
  input logic [ADDR_W-1:0] dst_addr,
  input logic              idx_valid,
  input logic [IDX_W-1:0]  idx
);
  logic unused_chk_bits;
  assign unused_chk_bits = ^dst_addr;

  logic key_zero;
  assign key_zero = (dst_addr[KEY_LSB +: KEY_W] == '0);

  logic wrote_any;
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)     wrote_any <= 1'b0;
    else if (row_we) wrote_any <= 1'b1;
  end

  // R4
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    key_valid |=> idx_valid);

  // R4
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !key_valid |=> !idx_valid);

  // R4
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !key_valid |=> $stable(idx));

  // R7
  zero_key_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (key_valid && key_zero) |=> (idx == '0));

  // R1
  clean_matrix_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (key_valid && !wrote_any) |=> (idx == '0));
endmodule

bind h3_index_unit h3_index_chk #(.KEY_LSB(KEY_LSB), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .row_we    (row_we),
  .key_valid (key_valid),
  .dst_addr  (dst_addr),
  .idx_valid (idx_valid),
  .idx       (idx)
);

// File: tb/h3_index_unit_tb.sv
`timescale 1ns/1ps
module h3_index_unit_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic        rst_n;
  logic        key_valid;
  logic [31:0] dst_addr;

  logic        a_we;   logic [3:0] a_sel;  logic [7:0] a_data;
  logic        a_vld;  logic [7:0] a_idx;
  logic        b_we;   logic [4:0] b_sel;  logic [7:0] b_data;
  logic        b_vld;  logic [7:0] b_idx;

  h3_index_unit u_dut (
    .clk(clk), .rst_n(rst_n), .row_we(a_we), .row_sel(a_sel), .row_data(a_data),
    .key_valid(key_valid), .dst_addr(dst_addr), .idx_valid(a_vld), .idx(a_idx)
  );

  // Second bank: full 32-bit key variant (R8, R9)
  h3_index_unit #(.KEY_LSB(0), .KEY_W(32)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .row_we(b_we), .row_sel(b_sel), .row_data(b_data),
    .key_valid(key_valid), .dst_addr(dst_addr), .idx_valid(b_vld), .idx(b_idx)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Bank A matrix: row k<8 = 1<<k, row k>=8 = 0x80>>(k-8)
  // => idx = key[7:0] ^ bitrev(key[15:8]), key = dst_addr[23:8]
  typedef struct packed { logic [31:0] a; logic [7:0] e; } vec_t;
  localparam vec_t VECS [10] = '{
    '{32'h0000_0000, 8'h00}, '{32'h0000_0100, 8'h01}, '{32'h0001_0000, 8'h80},
    '{32'hFF00_00FF, 8'h00}, '{32'h00FF_FF00, 8'h00}, '{32'h0012_3400, 8'h7C},
    '{32'hAB5A_A5CD, 8'hFF}, '{32'h00C3_0F00, 8'hCC}, '{32'h0080_0000, 8'h01},
    '{32'h7700_8000, 8'h80}
  };

  // Bank B matrix: row k = 1<<(k%8) => idx = XOR of the four address bytes
  function automatic logic [7:0] ref_b(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24];
  endfunction

  task automatic wr_a(input int k, input logic [7:0] d);
    @(negedge clk); a_we = 1; a_sel = 4'(k); a_data = d;
    @(negedge clk); a_we = 0;
  endtask

  task automatic wr_b(input int k, input logic [7:0] d);
    @(negedge clk); b_we = 1; b_sel = 5'(k); b_data = d;
    @(negedge clk); b_we = 0;
  endtask

  task automatic look(input logic [31:0] a);
    @(negedge clk); key_valid = 1; dst_addr = a;
    @(negedge clk); key_valid = 0;
  endtask

  initial begin
    rst_n = 0; key_valid = 0; dst_addr = '0;
    a_we = 0; a_sel = '0; a_data = '0; b_we = 0; b_sel = '0; b_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state and clean matrix
    chk("R1 idx_valid after reset", a_vld, 0);
    chk("R1 idx after reset", a_idx, 0);
    look(32'hDEAD_BEEF);
    chk("R1 lookup before writes", a_idx, 0);
    chk("R1 bank B lookup before writes", b_idx, 0);

    for (int k = 0; k < 16; k++) wr_a(k, (k < 8) ? 8'(1 << k) : 8'(8'h80 >> (k - 8)));
    for (int k = 0; k < 32; k++) wr_b(k, 8'(1 << (k % 8)));

    // R2 R3 R7 R9 vector table
    for (int v = 0; v < 10; v++) begin
      look(VECS[v].a);
      chk("R4 idx_valid after lookup", a_vld, 1);
      chk("R2/R3/R7 bank A index", a_idx, VECS[v].e);
      chk("R9 full-key bank B index", b_idx, ref_b(VECS[v].a));
    end

    // R4: no lookup -> valid drops, idx holds
    @(negedge clk); dst_addr = 32'h0000_FF00;
    @(negedge clk);
    chk("R4 idx_valid low without key", a_vld, 0);
    chk("R4 idx holds without key", a_idx, 8'h80);

    // R6 + R5: write row 0 in the same cycle as a lookup on key bit 0
    @(negedge clk);
    a_we = 1; a_sel = 4'd0; a_data = 8'h55;
    key_valid = 1; dst_addr = 32'h0000_0100;
    @(negedge clk);
    a_we = 0; key_valid = 0;
    chk("R6 same-cycle lookup uses old row", a_idx, 8'h01);
    look(32'h0000_0100);
    chk("R5 row 0 rewritten", a_idx, 8'h55);
    look(32'h0000_8100);  // key bits 0 and 7
    chk("R5 rewritten row combines with row 7", a_idx, 8'hD5);

    // R8: bank B unaffected by bank A writes
    chk("R8 bank B independent", b_idx, ref_b(32'h0000_8100));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule